// File: doc/BRIEF.md
# Descriptor DMA Channel Control Front-End

This block is the per-channel control and status front-end of a descriptor-based DMA controller. Software reaches it over a simple 32-bit word register bus. Each channel has its own 8 KiB window above a base address. For every channel the block holds the following:

- the pointer registers: current data descriptor, current buffer position, group and group-down;
- the configuration word;
- the interrupt mask;
- the raw interrupt bits;
- the last command and stream-command words.

A status read reports the live channel state and the end-of-list flag.

Stream commands fetch a data descriptor, a context descriptor or both through a single-word memory read port. A data fetch can also start the channel. A write to the command register attempts a conditional resume. The resume restarts a channel that stopped at the end of its list, but only after software has cleared the end flag in the descriptor it stopped on. The companion data engine moves the data. It receives a start strobe and a descriptor-loaded strobe from this block. It reports back end-of-list and interrupt causes. Each channel drives one level interrupt.

Top module: `dma_chan_front`

## Requirements
- R1: The channel index is (address − BASE) >> 13 and the register offset is address[12:0]. An address whose index is not below NCH is ignored on write and reads as zero.
- R2: These offsets read back what was last written:
  - 0x58 descriptor pointer;
  - 0x5C buffer pointer;
  - 0x60 group;
  - 0x7C group-down;
  - 0x80 command;
  - 0x84 config;
  - 0x8C mask;
  - 0x9C stream command.

  Offset 0x90 (acknowledge) always reads zero. Writes to any other offset are ignored, and reads of any other offset return zero.
- R3: Status at 0x88 holds the state in bits [2:0] (reset 0, stopped 2, running 4) and the end-of-list flag in bit 5. All other bits read zero. After reset a channel reads 0.
- R4: A stream-command write with any of bits 0x140 set fetches the data descriptor at the descriptor pointer, using only bits [9:0]:
  - word +0 is the next pointer;
  - word +4 is the buffer start;
  - word +8 bit 0 is the end flag.

  The buffer start is copied into the buffer pointer, and `load_pulse` pulses once for that channel.
- R5: If bit 0x20 is also set and the channel's client is attached, the fetch ends with the channel running, its end-of-list flag cleared, and one `start_pulse`. Without a client the channel is not started.
- R6: Bit 0x200 fetches the context descriptor at the group-down pointer. Word +24 goes to the descriptor pointer and word +28 goes to the buffer pointer. When 0x200 is combined with a data load, the context fetch comes after the data fetch.
- R7: A command-register write makes no memory request unless all of these hold:
  - config bit 0 is set;
  - the client is attached;
  - config bit 1 is clear;
  - the state is running;
  - the last loaded data descriptor had its end flag set.
- R8: When the conditions of R7 hold, the descriptor is fetched again. If its end flag is now clear and the channel's end-of-list flag is set, the following happen:
  - the descriptor pointer moves to the next pointer;
  - that descriptor is fetched;
  - the end-of-list flag clears;
  - the channel runs;
  - `start_pulse` fires once.
- R9: If the refetched descriptor still has its end flag set, there is exactly one fetch and no start.
- R10: An engine cause pulse ORs bits into raw (0x94). Writing 0x90 clears the written bits from raw. Masked (0x98) reads raw AND mask, and `irq` is high exactly when masked is nonzero.
- R11: `mem_req` stays high with a stable `mem_addr` until `mem_ack`.
- R12: While `busy` is high, bus writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 32 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| busy | output | 1 | Descriptor fetch in progress |
| client_on | input | NCH | Client attached, per channel |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 32 | Memory word address |
| mem_ack | input | 1 | Memory data valid |
| mem_rdata | input | 32 | Memory read data |
| eng_eol | input | NCH | Engine reached end of list, per channel |
| eng_cause | input | NCH*CW_I | Engine interrupt cause bits, CW_I per channel |
| start_pulse | output | NCH | Channel start strobe |
| load_pulse | output | NCH | Data descriptor loaded strobe |
| irq | output | NCH | Level interrupt per channel |

## Verification
Stream commands are issued with each of the two load-data bits, with and without burst, with and without an attached client, with context only, and with data plus context. The combined case tells the fetch order apart by which buffer pointer survives. The resume command is tried in several situations:

- with the channel stopped or disabled, which must cause no fetch;
- with the end flag still set, which must cause one fetch and no start;
- with the end flag cleared, which must cause two fetches and a start.

Random register traffic on all channels is checked against a bench copy of each register. This exposes crossed channel decode. Random cause, mask and acknowledge sequences check the interrupt path against a model.

// File: rtl/dma_chan_front.sv
module dma_chan_front #(
  parameter int          NCH  = 4,
  parameter int          CW_I = 4,
  parameter logic [31:0] BASE = 32'h0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [31:0]           bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  busy,
  input  logic [NCH-1:0]        client_on,
  output logic                  mem_req,
  output logic [31:0]           mem_addr,
  input  logic                  mem_ack,
  input  logic [31:0]           mem_rdata,
  input  logic [NCH-1:0]        eng_eol,
  input  logic [NCH*CW_I-1:0]   eng_cause,
  output logic [NCH-1:0]        start_pulse,
  output logic [NCH-1:0]        load_pulse,
  output logic [NCH-1:0]        irq
);
  localparam int CB = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [2:0] ST_RST = 3'd0, ST_RUN = 3'd4;
  localparam logic [12:0] O_DP = 13'h58, O_BP = 13'h5C, O_GRP = 13'h60, O_GDN = 13'h7C,
    O_CMD = 13'h80, O_CFG = 13'h84, O_STAT = 13'h88, O_MSK = 13'h8C, O_ACK = 13'h90,
    O_RAW = 13'h94, O_MSKD = 13'h98, O_SCMD = 13'h9C;

  typedef enum logic [2:0] {SQ_IDLE, SQ_DN, SQ_DB, SQ_DF, SQ_CA, SQ_CB} sq_t;

  logic [31:0] r_dp [NCH], r_bp [NCH], r_grp [NCH], r_gdn [NCH], r_cmd [NCH];
  logic [31:0] r_cfg [NCH], r_msk [NCH], r_raw [NCH], r_scmd [NCH];
  logic [2:0]  st [NCH];
  logic        ch_eol [NCH], d_eol [NCH];

  sq_t         sq;
  logic [CB-1:0] sq_ch;
  logic [31:0] sq_base, t_next, t_buf;
  logic        op_burst, op_ctx;
  logic [1:0]  cont;

  logic [31:0] rel;
  logic [12:0] off;
  logic        chv;
  logic [CB-1:0] ch;
  logic        wr_ok;

  assign rel   = bus_addr - BASE;
  assign off   = bus_addr[12:0];
  assign chv   = ({13'd0, rel[31:13]} < NCH);
  assign ch    = rel[CB+12:13];
  assign busy  = (sq != SQ_IDLE);
  assign wr_ok = bus_wr && chv && !busy;

  assign mem_req = busy;
  always_comb begin
    case (sq)
      SQ_DB:   mem_addr = sq_base + 32'd4;
      SQ_DF:   mem_addr = sq_base + 32'd8;
      SQ_CA:   mem_addr = sq_base + 32'd24;
      SQ_CB:   mem_addr = sq_base + 32'd28;
      default: mem_addr = sq_base;
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_irq
      assign irq[g] = |(r_raw[g] & r_msk[g]);
    end
  endgenerate

  always_comb begin
    bus_rdata = 32'h0;
    if (chv) begin
      case (off)
        O_DP:   bus_rdata = r_dp[ch];
        O_BP:   bus_rdata = r_bp[ch];
        O_GRP:  bus_rdata = r_grp[ch];
        O_GDN:  bus_rdata = r_gdn[ch];
        O_CMD:  bus_rdata = r_cmd[ch];
        O_CFG:  bus_rdata = r_cfg[ch];
        O_STAT: bus_rdata = {26'h0, ch_eol[ch], 2'b00, st[ch]};
        O_MSK:  bus_rdata = r_msk[ch];
        O_RAW:  bus_rdata = r_raw[ch];
        O_MSKD: bus_rdata = r_raw[ch] & r_msk[ch];
        O_SCMD: bus_rdata = r_scmd[ch];
        default: bus_rdata = 32'h0;
      endcase
    end
  end

  logic        can_cont;
  logic        sc_ld, sc_lc;
  assign can_cont = r_cfg[ch][0] && client_on[ch] && !r_cfg[ch][1] && st[ch] == ST_RUN && d_eol[ch];
  assign sc_ld    = |(bus_wdata[9:0] & 10'h140);
  assign sc_lc    = bus_wdata[9];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        r_dp[i] <= '0; r_bp[i] <= '0; r_grp[i] <= '0; r_gdn[i] <= '0; r_cmd[i] <= '0;
        r_cfg[i] <= '0; r_msk[i] <= '0; r_raw[i] <= '0; r_scmd[i] <= '0;
        st[i] <= ST_RST; ch_eol[i] <= 1'b0; d_eol[i] <= 1'b0;
      end
      sq <= SQ_IDLE; sq_ch <= '0; sq_base <= '0; t_next <= '0; t_buf <= '0;
      op_burst <= 1'b0; op_ctx <= 1'b0; cont <= 2'd0;
      start_pulse <= '0; load_pulse <= '0;
    end else begin
      start_pulse <= '0;
      load_pulse  <= '0;

      if (wr_ok) begin
        case (off)
          O_DP:  r_dp[ch]  <= bus_wdata;
          O_BP:  r_bp[ch]  <= bus_wdata;
          O_GRP: r_grp[ch] <= bus_wdata;
          O_GDN: r_gdn[ch] <= bus_wdata;
          O_CFG: r_cfg[ch] <= bus_wdata;
          O_MSK: r_msk[ch] <= bus_wdata;
          O_CMD: begin
            r_cmd[ch] <= bus_wdata;
            if (can_cont) begin
              sq <= SQ_DN; sq_ch <= ch; sq_base <= r_dp[ch];
              cont <= 2'd1; op_burst <= 1'b0; op_ctx <= 1'b0;
            end
          end
          O_SCMD: begin
            r_scmd[ch] <= bus_wdata;
            sq_ch <= ch; cont <= 2'd0;
            op_burst <= bus_wdata[5]; op_ctx <= sc_lc;
            if (sc_ld) begin
              sq <= SQ_DN; sq_base <= r_dp[ch];
            end else if (sc_lc) begin
              sq <= SQ_CA; sq_base <= r_gdn[ch];
            end
          end
          default: ;
        endcase
      end

      if (mem_ack) begin
        case (sq)
          SQ_DN: begin t_next <= mem_rdata; sq <= SQ_DB; end
          SQ_DB: begin t_buf  <= mem_rdata; sq <= SQ_DF; end
          SQ_DF: begin
            r_bp[sq_ch]  <= t_buf;
            d_eol[sq_ch] <= mem_rdata[0];
            load_pulse[sq_ch] <= 1'b1;
            sq <= SQ_IDLE;
            if (cont == 2'd1) begin
              if (!mem_rdata[0] && ch_eol[sq_ch]) begin
                r_dp[sq_ch] <= t_next; sq_base <= t_next; cont <= 2'd2; sq <= SQ_DN;
              end
            end else if (cont == 2'd2) begin
              if (client_on[sq_ch]) begin
                st[sq_ch] <= ST_RUN; ch_eol[sq_ch] <= 1'b0; start_pulse[sq_ch] <= 1'b1;
              end
            end else begin
              if (op_burst && client_on[sq_ch]) begin
                st[sq_ch] <= ST_RUN; ch_eol[sq_ch] <= 1'b0; start_pulse[sq_ch] <= 1'b1;
              end
              if (op_ctx) begin
                sq <= SQ_CA; sq_base <= r_gdn[sq_ch];
              end
            end
          end
          SQ_CA: begin r_dp[sq_ch] <= mem_rdata; sq <= SQ_CB; end
          SQ_CB: begin r_bp[sq_ch] <= mem_rdata; sq <= SQ_IDLE; end
          default: ;
        endcase
      end

      for (int i = 0; i < NCH; i++) begin
        if (eng_eol[i]) ch_eol[i] <= 1'b1;
        if (wr_ok && off == O_ACK && ch == CB'(i))
          r_raw[i] <= (r_raw[i] & ~bus_wdata) | {{(32-CW_I){1'b0}}, eng_cause[i*CW_I +: CW_I]};
        else
          r_raw[i] <= r_raw[i] | {{(32-CW_I){1'b0}}, eng_cause[i*CW_I +: CW_I]};
      end
    end
  end

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  // R4
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(load_pulse));
  // R5
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(start_pulse));

  generate
    for (g = 0; g < NCH; g++) begin : g_chk
      logic ack_hit;
      assign ack_hit = wr_ok && off == O_ACK && ch == CB'(g);
      // R5
      start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse[g] |-> st[g] == ST_RUN);
      // R3
      state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st[g] == 3'd0 || st[g] == 3'd2 || st[g] == 3'd4);
      // R10
      ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit && eng_cause[g*CW_I +: CW_I] == '0 |=> (r_raw[g] & $past(bus_wdata)) == 32'h0);
      // R12
      busy_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(r_cfg[g]) && $stable(r_msk[g]));
    end
  endgenerate
endmodule

// File: tb/dma_chan_front_test.sv
module dma_chan_front_test;
  localparam int NCH = 4;
  localparam int CWI = 4;
  localparam logic [31:0] TB_BASE = 32'h0010_0000;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic busy;
  logic [NCH-1:0] client_on = 0;
  logic mem_req, mem_ack = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic [NCH-1:0] eng_eol = 0;
  logic [NCH*CWI-1:0] eng_cause = 0;
  logic [NCH-1:0] start_pulse, load_pulse, irq;

  dma_chan_front #(.NCH(NCH), .CW_I(CWI), .BASE(TB_BASE)) uut (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .busy, .client_on,
    .mem_req, .mem_addr, .mem_ack, .mem_rdata, .eng_eol, .eng_cause,
    .start_pulse, .load_pulse, .irq);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  bit stall_mem = 0;
  logic [31:0] bmem [256];
  int ld_cnt [NCH], st_cnt [NCH];
  logic [31:0] m_reg [NCH][6];
  logic [31:0] m_raw [NCH], m_msk [NCH];

  function automatic logic [31:0] A(int c, logic [12:0] o);
    return TB_BASE + 32'(c) * 32'h2000 + {19'h0, o};
  endfunction
  function automatic logic [12:0] rw_off(int k);
    case (k)
      0: return 13'h58; 1: return 13'h5C; 2: return 13'h60;
      3: return 13'h7C; 4: return 13'h84; default: return 13'h8C;
    endcase
  endfunction
  function automatic logic exp_irq(logic [31:0] r, logic [31:0] m);
    return |(r & m);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask
  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(logic [31:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask
  task automatic wait_idle();
    int n = 0;
    while (busy && n < 300) begin @(negedge clk); n++; end
    if (busy) chk("R11 fetch finishes", 32'(busy), 0);
    repeat (2) @(negedge clk);
  endtask
  task automatic cause(int c, logic [CWI-1:0] b);
    @(negedge clk); eng_cause[c*CWI +: CWI] = b;
    @(negedge clk); eng_cause = '0;
  endtask

  always @(negedge clk)
    for (int i = 0; i < NCH; i++) begin
      if (load_pulse[i]) ld_cnt[i]++;
      if (start_pulse[i]) st_cnt[i]++;
    end

  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !stall_mem) begin
        repeat ($urandom % 3) @(negedge clk);
        mem_ack = 1; mem_rdata = bmem[mem_addr[9:2]];
        @(negedge clk); mem_ack = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int l0, s0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) bmem[i] = 32'hC0DE_0000 + 32'(i);
    for (int i = 0; i < NCH; i++) begin ld_cnt[i] = 0; st_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(A(0, 13'h88), v); chk("R3 reset status", v, 0);
    chk("R10 reset irq", 32'(irq), 0);
    chk("R11 reset mem_req", 32'(mem_req), 0);

    // R4 data load without start
    bmem[8'h40] = 32'h200; bmem[8'h41] = 32'h3A0; bmem[8'h42] = 32'h1;
    wr(A(1, 13'h58), 32'h100);
    l0 = ld_cnt[1];
    wr(A(1, 13'h9C), 32'h040); wait_idle();
    rd(A(1, 13'h5C), v); chk("R4 buffer start copied", v, 32'h3A0);
    chk("R4 one load pulse", 32'(ld_cnt[1] - l0), 1);
    rd(A(1, 13'h9C), v); chk("R2 stream cmd readback", v, 32'h040);

    // R5 burst with no client
    s0 = st_cnt[1];
    wr(A(1, 13'h9C), 32'h160); wait_idle();
    rd(A(1, 13'h88), v); chk("R5 no client no start", v, 0);
    chk("R5 no start pulse", 32'(st_cnt[1] - s0), 0);

    // R5 burst with client, using bit 0x100 only
    client_on = 4'b1111;
    l0 = ld_cnt[1];
    wr(A(1, 13'h9C), 32'h120); wait_idle();
    rd(A(1, 13'h88), v); chk("R5 running after burst", v, 32'h4);
    chk("R5 start pulse", 32'(st_cnt[1] - s0), 1);
    chk("R4 load via 0x100", 32'(ld_cnt[1] - l0), 1);

    // R4 high bits ignored
    l0 = ld_cnt[1];
    wr(A(1, 13'h9C), 32'hFC00); wait_idle();
    chk("R4 bits above 9 ignored", 32'(ld_cnt[1] - l0), 0);

    // R6 context load
    bmem[8'hC6] = 32'h100; bmem[8'hC7] = 32'h1234;
    wr(A(2, 13'h7C), 32'h300);
    wr(A(2, 13'h9C), 32'h200); wait_idle();
    rd(A(2, 13'h58), v); chk("R6 context dp", v, 32'h100);
    rd(A(2, 13'h5C), v); chk("R6 context bp", v, 32'h1234);
    l0 = ld_cnt[2];
    wr(A(2, 13'h9C), 32'h240); wait_idle();
    rd(A(2, 13'h5C), v); chk("R6 context after data", v, 32'h1234);
    chk("R6 data load happened", 32'(ld_cnt[2] - l0), 1);

    // R7/R8/R9 resume on channel 1
    @(negedge clk); eng_eol[1] = 1; @(negedge clk); eng_eol = 0;
    rd(A(1, 13'h88), v); chk("R3 eol bit 5", v, 32'h24);
    wr(A(1, 13'h84), 32'h3);
    l0 = ld_cnt[1];
    wr(A(1, 13'h80), 32'h1); repeat (4) @(negedge clk);
    chk("R7 stopped no fetch", 32'(ld_cnt[1] - l0), 0);
    wr(A(1, 13'h84), 32'h0);
    wr(A(1, 13'h80), 32'h1); repeat (4) @(negedge clk);
    chk("R7 disabled no fetch", 32'(ld_cnt[1] - l0), 0);
    wr(A(1, 13'h84), 32'h1);
    s0 = st_cnt[1];
    wr(A(1, 13'h80), 32'h1); wait_idle();
    chk("R9 single refetch", 32'(ld_cnt[1] - l0), 1);
    chk("R9 no start", 32'(st_cnt[1] - s0), 0);
    rd(A(1, 13'h88), v); chk("R9 status kept", v, 32'h24);
    bmem[8'h42] = 32'h0; bmem[8'h81] = 32'h5B0; bmem[8'h82] = 32'h1;
    l0 = ld_cnt[1];
    wr(A(1, 13'h80), 32'h1); wait_idle();
    chk("R8 two fetches", 32'(ld_cnt[1] - l0), 2);
    chk("R8 start pulse", 32'(st_cnt[1] - s0), 1);
    rd(A(1, 13'h88), v); chk("R8 running eol clear", v, 32'h4);
    rd(A(1, 13'h58), v); chk("R8 dp moved to next", v, 32'h200);
    rd(A(1, 13'h5C), v); chk("R8 bp from next desc", v, 32'h5B0);

    // R10 interrupts
    cause(3, 4'b1010);
    chk("R10 masked off irq low", 32'(irq[3]), 0);
    rd(A(3, 13'h94), v); chk("R10 raw set", v, 32'hA);
    wr(A(3, 13'h8C), 32'h2);
    chk("R10 irq high", 32'(irq[3]), 1);
    rd(A(3, 13'h98), v); chk("R10 masked", v, 32'h2);
    wr(A(3, 13'h90), 32'h2);
    rd(A(3, 13'h94), v); chk("R10 ack clears", v, 32'h8);
    chk("R10 irq low after ack", 32'(irq[3]), 0);
    rd(A(3, 13'h90), v); chk("R2 ack reads zero", v, 0);

    // R12 writes ignored while busy
    stall_mem = 1;
    wr(A(0, 13'h9C), 32'h040);
    chk("R12 busy high", 32'(busy), 1);
    wr(A(0, 13'h84), 32'h55);
    stall_mem = 0; wait_idle();
    rd(A(0, 13'h84), v); chk("R12 cfg unchanged", v, 0);

    // R1/R2 decode corners
    wr(A(0, 13'h10), 32'hDEAD);
    rd(A(0, 13'h10), v); chk("R2 undefined offset zero", v, 0);
    wr(A(NCH, 13'h84), 32'h77);
    rd(A(NCH, 13'h84), v); chk("R1 out of range zero", v, 0);
    rd(A(0, 13'h84), v); chk("R1 no alias on ch0", v, 0);
    rd(TB_BASE - 32'h2000 + 32'h84, v); chk("R1 below base zero", v, 0);

    // R1/R2 random register traffic
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 6; k++) begin rd(A(c, rw_off(k)), v); m_reg[c][k] = v; end
    for (int n = 0; n < 200; n++) begin
      int c = $urandom % NCH;
      int k = $urandom % 6;
      logic [31:0] d = $urandom;
      if (k == 4) d[1:0] = 2'b00;
      wr(A(c, rw_off(k)), d); m_reg[c][k] = d;
      c = $urandom % NCH; k = $urandom % 6;
      rd(A(c, rw_off(k)), v); chk("R1 R2 random readback", v, m_reg[c][k]);
    end

    // R10 random interrupt sequences
    for (int c = 0; c < NCH; c++) begin
      rd(A(c, 13'h94), v); m_raw[c] = v;
      rd(A(c, 13'h8C), v); m_msk[c] = v;
    end
    for (int n = 0; n < 150; n++) begin
      int c = $urandom % NCH;
      logic [31:0] d = $urandom;
      case ($urandom % 3)
        0: begin cause(c, d[CWI-1:0]); m_raw[c] = m_raw[c] | {28'h0, d[CWI-1:0]}; end
        1: begin wr(A(c, 13'h8C), d); m_msk[c] = d; end
        default: begin wr(A(c, 13'h90), d); m_raw[c] = m_raw[c] & ~d; end
      endcase
      rd(A(c, 13'h98), v); chk("R10 random masked", v, m_raw[c] & m_msk[c]);
      chk("R10 random irq", 32'(irq[c]), 32'(exp_irq(m_raw[c], m_msk[c])));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule